// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block picks one interrupt to hand to a processor out of a bank of vectored sources. Each source carries a two-bit level tag (off, low, medium or high), and each of the three levels can be switched on or off through a control register. Between levels the order is fixed: high beats medium, and medium beats low. Inside the medium and high levels the lowest vector number wins. Low-level sources can be scheduled in turn, which stops a busy low source from starving the others.

The turn-taking order comes from a priority register that holds the last low-level vector taken. The search for a winner starts at the vector after the stored one. That register keeps its value when turn-taking is switched off, and a nonzero value still moves the starting point of the search. Software restores plain lowest-first order by writing zero to it.

The block reports the winning vector and its entry address. The address is the selected base (application or boot region) plus four times the vector number. An acknowledge marks the winner's level as executing in a status register. A return clears the highest executing level. A new winner is offered only if its level is above every level that is executing.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the control, priority and status registers read zero and `irqValid` is low.
- R2: A source whose level is switched off in the control register (bit 0 low, bit 1 medium, bit 2 high) never wins. A source tagged 0 never wins either. The tags are 1 low, 2 medium, 3 high.
- R3: A requesting high source beats any medium or low source, and a medium source beats any low source, whatever the vector numbers.
- R4: Among medium or high sources the lowest vector number wins. The same holds for low sources when control bit 7 is clear and the priority register is zero.
- R5: With control bit 7 set, the low-level search starts at the priority register value plus one and wraps past the top vector. An acknowledged low winner is written into the priority register.
- R6: Clearing control bit 7 leaves the priority register unchanged. While the bit is clear, a nonzero priority register still starts the low search one vector after it, and acknowledges do not update the register.
- R7: `irqVecAddr` equals the base plus 4 times `irqVector`. The base is the application base when control bit 6 is clear and the boot base when it is set.
- R8: Register reads at offset 0 return the status, at 1 the priority and at 2 the control register. Control bits 5:3 always read zero. Offset 3 reads zero.
- R9: An accepted acknowledge sets the status bit of the winner's level (bit 0 low, 1 medium, 2 high). A return clears the highest set status bit.
- R10: `irqValid` is high only when the winner's level is above the highest level set in the status register.
- R11: An acknowledge that arrives together with a return, or while `irqValid` is low, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_VEC | Request line per vector |
| irqLevel | input | 2*NUM_VEC | Level tag per vector, two bits each, vector 0 lowest |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from `regAddr` |
| ack | input | 1 | Processor takes the offered vector |
| reti | input | 1 | Processor returns from the current level |
| irqValid | output | 1 | A vector is offered |
| irqVector | output | VEC_W | Offered vector number |
| irqVecAddr | output | ADDR_W | Entry address of the offered vector |

## Verification
The arbitration outputs and the register read port are combinational. A change on `irqReq`, `irqLevel` or `regAddr` is therefore visible in the same cycle. Register writes, acknowledges and returns act at one rising edge, and their effect is visible from the next falling edge on. The bench drives every input on a falling edge, steps through exactly one rising edge per write, acknowledge or return, and samples a short delay after the following falling edge. No check can straddle the edge that updates the state it reads.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_MED  = 2'd2,
    LVL_HIGH = 2'd3
  } lvl_e;

  localparam logic [1:0] REG_STATUS = 2'd0;
  localparam logic [1:0] REG_PRIO   = 2'd1;
  localparam logic [1:0] REG_CTRL   = 2'd2;

  localparam int CTRL_RR_BIT   = 7;
  localparam int CTRL_BASE_BIT = 6;
  localparam logic [7:0] CTRL_MASK = 8'hC7;

  localparam int VEC_SIZE  = 4;
  localparam int VEC_SHIFT = $clog2(VEC_SIZE);

  // strobes from the arbiter to the register datapath
  typedef struct packed {
    logic take;      // accepted acknowledge
    lvl_e takeLvl;   // level of the taken vector
    logic lowTake;   // take that rotates the priority register
    logic retire;    // return from the highest executing level
  } strobe_t;

endpackage

// File: rtl/lvl_irq_arb.sv
module lvl_irq_arb
  import lvl_irq_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0]   irqReq,
  input  logic [2*NUM_VEC-1:0] irqLevel,
  input  logic [2:0]           levelEn,
  input  logic                 rrEn,
  input  logic [VEC_W-1:0]     prioQ,
  input  logic [2:0]           statusQ,
  input  logic                 ack,
  input  logic                 reti,
  output logic                 winValid,
  output logic [VEC_W-1:0]     winVec,
  output strobe_t              strobe
);

  localparam logic [VEC_W-1:0] TOP_VEC = VEC_W'(NUM_VEC - 1);

  logic [NUM_VEC-1:0] lowMask, medMask, highMask;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_mask
    logic [1:0] tag;
    assign tag         = irqLevel[2*v +: 2];
    assign lowMask[v]  = irqReq[v] && (tag == LVL_LOW)  && levelEn[0];
    assign medMask[v]  = irqReq[v] && (tag == LVL_MED)  && levelEn[1];
    assign highMask[v] = irqReq[v] && (tag == LVL_HIGH) && levelEn[2];
  end

  // first set bit of m, searching upward from s with wrap
  function automatic logic [VEC_W:0] pickFrom(input logic [NUM_VEC-1:0] m,
                                              input logic [VEC_W-1:0] s);
    logic [VEC_W:0] r;
    int idx;
    r = '0;
    for (int k = NUM_VEC - 1; k >= 0; k--) begin
      idx = int'(s) + k;
      if (idx >= NUM_VEC) idx = idx - NUM_VEC;
      if (m[idx[VEC_W-1:0]]) r = {1'b1, idx[VEC_W-1:0]};
    end
    return r;
  endfunction

  logic [VEC_W-1:0] lowStart;
  logic [VEC_W:0]   lowPick, medPick, highPick;
  lvl_e             winLvl, execLvl;

  always_comb begin
    if (rrEn || (prioQ != '0))
      lowStart = (prioQ == TOP_VEC) ? '0 : prioQ + 1'b1;
    else
      lowStart = '0;
  end

  assign lowPick  = pickFrom(lowMask, lowStart);
  assign medPick  = pickFrom(medMask, '0);
  assign highPick = pickFrom(highMask, '0);

  always_comb begin
    if (highPick[VEC_W]) begin
      winLvl = LVL_HIGH;
      winVec = highPick[VEC_W-1:0];
    end else if (medPick[VEC_W]) begin
      winLvl = LVL_MED;
      winVec = medPick[VEC_W-1:0];
    end else if (lowPick[VEC_W]) begin
      winLvl = LVL_LOW;
      winVec = lowPick[VEC_W-1:0];
    end else begin
      winLvl = LVL_NONE;
      winVec = '0;
    end
  end

  always_comb begin
    if (statusQ[2])      execLvl = LVL_HIGH;
    else if (statusQ[1]) execLvl = LVL_MED;
    else if (statusQ[0]) execLvl = LVL_LOW;
    else                 execLvl = LVL_NONE;
  end

  assign winValid = (winLvl > execLvl);

  always_comb begin
    strobe.take    = ack && winValid && !reti;
    strobe.takeLvl = winLvl;
    strobe.lowTake = ack && winValid && !reti && (winLvl == LVL_LOW) && rrEn;
    strobe.retire  = reti;
  end

endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int VEC_W  = 3,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] APP_BASE  = '0,
  parameter logic [ADDR_W-1:0] BOOT_BASE = ADDR_W'(16'h4000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  input  strobe_t           strobe,
  input  logic [VEC_W-1:0]  winVec,
  output logic [7:0]        ctrlQ,
  output logic [VEC_W-1:0]  prioQ,
  output logic [2:0]        statusQ,
  output logic [7:0]        regRdData,
  output logic [ADDR_W-1:0] vecAddr
);

  logic wrCtrl, wrPrio;
  assign wrCtrl = regWrEn && (regAddr == REG_CTRL);
  assign wrPrio = regWrEn && (regAddr == REG_PRIO);

  always_ff @(posedge clk) begin
    if (!rstN)       ctrlQ <= '0;
    else if (wrCtrl) ctrlQ <= regWrData & CTRL_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               prioQ <= '0;
    else if (wrPrio)         prioQ <= regWrData[VEC_W-1:0];
    else if (strobe.lowTake) prioQ <= winVec;
  end

  logic [2:0] statusD;
  always_comb begin
    statusD = statusQ;
    if (strobe.retire) begin
      if (statusQ[2])      statusD[2] = 1'b0;
      else if (statusQ[1]) statusD[1] = 1'b0;
      else if (statusQ[0]) statusD[0] = 1'b0;
    end else if (strobe.take) begin
      case (strobe.takeLvl)
        LVL_LOW:  statusD[0] = 1'b1;
        LVL_MED:  statusD[1] = 1'b1;
        LVL_HIGH: statusD[2] = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusD;
  end

  always_comb begin
    case (regAddr)
      REG_STATUS: regRdData = {5'b0, statusQ};
      REG_PRIO:   regRdData = 8'(prioQ);
      REG_CTRL:   regRdData = ctrlQ;
      default:    regRdData = '0;
    endcase
  end

  logic [ADDR_W-1:0] baseSel;
  assign baseSel = ctrlQ[CTRL_BASE_BIT] ? BOOT_BASE : APP_BASE;
  assign vecAddr = baseSel + (ADDR_W'(winVec) << VEC_SHIFT);

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = $clog2(NUM_VEC),
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] APP_BASE  = '0,
  parameter logic [ADDR_W-1:0] BOOT_BASE = ADDR_W'(16'h4000)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_VEC-1:0]   irqReq,
  input  logic [2*NUM_VEC-1:0] irqLevel,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [7:0]           regWrData,
  output logic [7:0]           regRdData,
  input  logic                 ack,
  input  logic                 reti,
  output logic                 irqValid,
  output logic [VEC_W-1:0]     irqVector,
  output logic [ADDR_W-1:0]    irqVecAddr
);

  logic [7:0]       ctrlQ;
  logic [VEC_W-1:0] prioQ;
  logic [2:0]       statusQ;
  strobe_t          strobe;

  lvl_irq_arb #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_arb (
    .irqReq   (irqReq),
    .irqLevel (irqLevel),
    .levelEn  (ctrlQ[2:0]),
    .rrEn     (ctrlQ[CTRL_RR_BIT]),
    .prioQ    (prioQ),
    .statusQ  (statusQ),
    .ack      (ack),
    .reti     (reti),
    .winValid (irqValid),
    .winVec   (irqVector),
    .strobe   (strobe)
  );

  lvl_irq_regs #(
    .VEC_W(VEC_W), .ADDR_W(ADDR_W), .APP_BASE(APP_BASE), .BOOT_BASE(BOOT_BASE)
  ) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobe    (strobe),
    .winVec    (irqVector),
    .ctrlQ     (ctrlQ),
    .prioQ     (prioQ),
    .statusQ   (statusQ),
    .regRdData (regRdData),
    .vecAddr   (irqVecAddr)
  );

endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
  parameter int VEC_W  = 3,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ack,
  input logic              reti,
  input logic              regWrEn,
  input logic [1:0]        regAddr,
  input logic [7:0]        regRdData,
  input logic              irqValid,
  input logic [ADDR_W-1:0] irqVecAddr,
  input logic [7:0]        ctrlQ,
  input logic [VEC_W-1:0]  prioQ,
  input logic [2:0]        statusQ
);

  // R10: nothing is offered while the high level executes
  assert_no_offer_in_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[2] |-> !irqValid);

  // R9: an accepted acknowledge adds exactly one executing level
  assert_ack_sets_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqValid && !reti) |=> ($countones(statusQ) == $countones($past(statusQ)) + 1));

  // R9: a return removes exactly one executing level
  assert_reti_clears_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reti && (statusQ != 3'b000)) |=> ($countones(statusQ) + 1 == $countones($past(statusQ))));

  // R11: an acknowledge paired with a return adds nothing
  assert_ack_with_reti_dropped_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ack && reti && (statusQ == 3'b000)) |=> (statusQ == 3'b000));

  // R6: with rotation off and no software write the priority register holds
  assert_prio_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[7] && !(regWrEn && regAddr == 2'd1)) |=> $stable(prioQ));

  // R8: reserved control bits read zero
  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2) |-> (regRdData[5:3] == 3'b000 && ctrlQ[5:3] == 3'b000));

  // R7: entry addresses stay on vector-size boundaries
  assert_addr_aligned_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (irqVecAddr[1:0] == 2'b00));

endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ack        (ack),
  .reti       (reti),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regRdData  (regRdData),
  .irqValid   (irqValid),
  .irqVecAddr (irqVecAddr),
  .ctrlQ      (ctrlQ),
  .prioQ      (prioQ),
  .statusQ    (statusQ)
);

// File: tb/lvl_irq_ctrl_test.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_test;

  localparam int NUM_VEC = 8;
  localparam int VEC_W   = 3;
  localparam int ADDR_W  = 16;
  localparam logic [15:0] APP_B  = 16'h0000;
  localparam logic [15:0] BOOT_B = 16'h4000;

  // tags: v0 low, v1 low, v2 med, v3 high, v4 low, v5 med, v6 low, v7 high
  localparam logic [15:0] LVL_MAP = {2'd3, 2'd1, 2'd2, 2'd1, 2'd3, 2'd2, 2'd1, 2'd1};

  logic clk = 0, rstN = 0;
  logic [NUM_VEC-1:0] irqReq = '0;
  logic [15:0] irqLevel = LVL_MAP;
  logic regWrEn = 0, ack = 0, reti = 0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0, regRdData;
  logic irqValid;
  logic [VEC_W-1:0] irqVector;
  logic [ADDR_W-1:0] irqVecAddr;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lvl_irq_ctrl #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .APP_BASE(APP_B), .BOOT_BASE(BOOT_B)) uut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqLevel(irqLevel),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .ack(ack), .reti(reti), .irqValid(irqValid), .irqVector(irqVector), .irqVecAddr(irqVecAddr)
  );

  // {ctrl, prio, req, expValid, expVec}
  localparam int NROWS = 15;
  localparam logic [22:0] TABLE [NROWS] = '{
    {8'h07, 3'd0, 8'h01, 1'b1, 3'd0},  // R4
    {8'h07, 3'd0, 8'h52, 1'b1, 3'd1},  // R4 low static
    {8'h07, 3'd0, 8'h89, 1'b1, 3'd3},  // R3 high first
    {8'h07, 3'd0, 8'h25, 1'b1, 3'd2},  // R3 med over low
    {8'h03, 3'd0, 8'h0A, 1'b1, 3'd1},  // R2 high off
    {8'h04, 3'd0, 8'h27, 1'b0, 3'd0},  // R2 only high on
    {8'h81, 3'd0, 8'h53, 1'b1, 3'd1},  // R5 start 1
    {8'h81, 3'd4, 8'h53, 1'b1, 3'd6},  // R5 start 5
    {8'h81, 3'd6, 8'h53, 1'b1, 3'd0},  // R5 wrap
    {8'h01, 3'd4, 8'h53, 1'b1, 3'd6},  // R6 stale start
    {8'h01, 3'd0, 8'h53, 1'b1, 3'd0},  // R4 restored
    {8'h07, 3'd6, 8'h0C, 1'b1, 3'd3},  // R4 high unaffected by prio
    {8'h06, 3'd0, 8'h00, 1'b0, 3'd0},  // R2 no request
    {8'h07, 3'd0, 8'h20, 1'b1, 3'd5},  // R3 med alone
    {8'h47, 3'd0, 8'h80, 1'b1, 3'd7}   // R7 boot base
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulse(input logic a, input logic r);
    @(negedge clk);
    ack = a; reti = r;
    @(negedge clk);
    ack = 0; reti = 0;
  endtask

  task automatic setReq(input logic [7:0] q);
    @(negedge clk);
    irqReq = q;
    #1;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1;
    irqReq = 8'hFF;
    // R1 reset state
    readReg(2'd0, rd); check("R1 status", rd, 0);
    readReg(2'd1, rd); check("R1 prio", rd, 0);
    readReg(2'd2, rd); check("R1 ctrl", rd, 0);
    check("R1 valid", irqValid, 0);
    // R8 reserved bits and offsets
    writeReg(2'd2, 8'hFF);
    readReg(2'd2, rd); check("R8 ctrl read", rd, 8'hC7);
    readReg(2'd3, rd); check("R8 offset 3", rd, 0);

    for (int i = 0; i < NROWS; i++) begin
      logic [7:0] c; logic [2:0] p; logic [7:0] q; logic ev; logic [2:0] evec;
      {c, p, q, ev, evec} = TABLE[i];
      writeReg(2'd2, c);
      writeReg(2'd1, {5'b0, p});
      setReq(q);
      check($sformatf("R2/R3/R4/R5 row %0d valid", i), irqValid, ev);
      if (ev) begin
        check($sformatf("R3/R4/R5/R6 row %0d vector", i), irqVector, evec);
        check($sformatf("R7 row %0d address", i), irqVecAddr,
              (c[6] ? BOOT_B : APP_B) + 16'(evec) * 16'd4);
      end
    end

    // R9 / R10 nesting
    writeReg(2'd1, 8'h00);
    writeReg(2'd2, 8'h07);
    setReq(8'h01);
    check("R10 idle offer", irqValid, 1);
    pulse(1, 0);
    readReg(2'd0, rd); check("R9 low set", rd, 8'h01);
    check("R10 same level blocked", irqValid, 0);
    setReq(8'h05);
    check("R10 med preempts", {irqValid, 4'(irqVector)}, {1'b1, 4'd2});
    pulse(1, 0);
    readReg(2'd0, rd); check("R9 med set", rd, 8'h03);
    setReq(8'h0D);
    check("R10 high preempts", {irqValid, 4'(irqVector)}, {1'b1, 4'd3});
    pulse(1, 0);
    readReg(2'd0, rd); check("R9 high set", rd, 8'h07);
    check("R10 none above high", irqValid, 0);
    pulse(0, 1);
    readReg(2'd0, rd); check("R9 reti clears high", rd, 8'h03);
    check("R10 high again after reti", {irqValid, 4'(irqVector)}, {1'b1, 4'd3});
    pulse(0, 1);
    readReg(2'd0, rd); check("R9 reti clears med", rd, 8'h01);
    pulse(0, 1);
    readReg(2'd0, rd); check("R9 reti clears low", rd, 8'h00);

    // R5 / R6 rotation via acknowledges
    writeReg(2'd2, 8'h81);
    setReq(8'h50);
    check("R5 first pick", irqVector, 4);
    pulse(1, 0);
    readReg(2'd1, rd); check("R5 prio updated", rd, 4);
    pulse(0, 1);
    setReq(8'h50);
    check("R5 rotated pick", {irqValid, 4'(irqVector)}, {1'b1, 4'd6});
    pulse(1, 0);
    pulse(0, 1);
    writeReg(2'd2, 8'h01);
    readReg(2'd1, rd); check("R6 prio kept after RR off", rd, 6);
    setReq(8'h51);
    check("R6 stale wrap pick", irqVector, 0);
    pulse(1, 0);
    readReg(2'd1, rd); check("R6 no update when RR off", rd, 6);
    pulse(0, 1);
    writeReg(2'd1, 8'h00);
    setReq(8'h50);
    check("R6 zero restores static", irqVector, 4);

    // R11 dropped acknowledges
    setReq(8'h01);
    pulse(1, 1);
    readReg(2'd0, rd); check("R11 ack with reti", rd, 0);
    setReq(8'h00);
    pulse(1, 0);
    readReg(2'd0, rd); check("R11 ack without offer", rd, 0);

    done = 1;
    summary();
  end

endmodule